// File: doc/BRIEF.md
# Staged Fuzzy-Degree Attack Classifier

This block turns twelve fuzzy membership degrees into a single attack/normal verdict. Four features are scored: Hamming distance, energy, peak power and mean power. Each has a Low, a Medium and a High degree, all unsigned 11-bit values. A start pulse takes a snapshot of all twelve degrees. The machine then visits one feature per cycle, always in the order Hamming distance, energy, peak power, mean power.

In each stage the block keeps only the degrees above a fixed threshold and picks the largest of them. On a tie the higher category wins. If High wins, the verdict is attack. If Low wins, the verdict is normal. If Medium wins, or no degree clears the threshold, the machine moves on to the next feature. When the mean-power stage gives no verdict, the result is normal.

The verdict is shown by a one-cycle done pulse and a registered attack flag. The flag keeps its value until the next verdict. The degrees come from an upstream fuzzifier, which is not part of this block.

Top module: `fuzzy_stage_classifier`

## Requirements
- R1: After reset, attackOut and doneOut are 0 and the block waits for a start pulse.
- R2: The degrees are sampled on the clock edge where startIn is seen in the idle state. Later changes on the degree inputs do not change that decision.
- R3: Stages run in the order Hamming, energy, peak, mean. A verdict reached at stage s (0 = Hamming, 3 = mean) raises doneOut on the (s+2)-th rising edge, counting the sampling edge as the first. A fall-through past mean raises doneOut on the 5th edge.
- R4: A degree is significant only when it is strictly greater than THRESH (default 8). A degree equal to 8 is not significant.
- R5: Within a stage, the largest significant degree selects the category.
- R6: When two or more significant degrees are equal, High has priority over Medium, and Medium over Low.
- R7: A High winner ends the run with attackOut = 1. A Low winner ends it with attackOut = 0. In both cases doneOut is asserted together with the new attackOut.
- R8: A Medium winner, or no significant degree, advances to the next stage. After the mean stage it ends with attackOut = 0.
- R9: doneOut stays high for exactly one cycle, then the block goes idle. attackOut holds its value until the next verdict.
- R10: startIn is ignored while a run is in progress.
- R11: Each feature bus packs three 11-bit degrees: Low in bits [10:0], Medium in [21:11], High in [32:22].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 100 MHz target |
| rstN | input | 1 | Asynchronous active-low reset |
| startIn | input | 1 | Start pulse; samples all degrees when idle |
| hamDeg | input | 33 | Hamming-distance degrees {High, Medium, Low} |
| energyDeg | input | 33 | Energy degrees {High, Medium, Low} |
| peakDeg | input | 33 | Peak-power degrees {High, Medium, Low} |
| meanDeg | input | 33 | Mean-power degrees {High, Medium, Low} |
| doneOut | output | 1 | One-cycle pulse marking a verdict |
| attackOut | output | 1 | Registered verdict, 1 = attack |

## Verification
A new start can arrive at the same time as an older run is still evaluating. The bench provokes this by holding startIn high, with different degrees that would give a fast High verdict, during the first evaluation cycle. It then requires the verdict and latency of the original snapshot. Verdict and done also share an edge: the attack flag must change only in the cycle where done is high. The bench checks this by sampling both signals on the expected edge and also in the idle cycles that follow.

// File: rtl/fzc_pkg.sv
package fzc_pkg;
  localparam int NUM_FEAT = 4;
  localparam int NUM_CAT  = 3;
  localparam int SEL_W    = $clog2(NUM_FEAT);
  localparam int CAT_LOW  = 0;
  localparam int CAT_MED  = 1;
  localparam int CAT_HIGH = 2;

  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_LOW  = 2'd1,
    WIN_MED  = 2'd2,
    WIN_HIGH = 2'd3
  } win_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_HAM  = 3'd1,
    ST_ENG  = 3'd2,
    ST_PEAK = 3'd3,
    ST_MEAN = 3'd4,
    ST_ATK  = 3'd5,
    ST_NORM = 3'd6
  } state_e;

  typedef struct packed {
    logic             capture;
    logic [SEL_W-1:0] featSel;
  } ctrl_s;
endpackage

// File: rtl/fzc_datapath.sv
module fzc_datapath
  import fzc_pkg::*;
#(
  parameter int DEG_W  = 11,
  parameter int THRESH = 8
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  ctrl_s                             ctrl,
  input  logic [NUM_FEAT*NUM_CAT*DEG_W-1:0] degBus,
  output win_e                              win
);
  localparam int BUS_W = NUM_FEAT * NUM_CAT * DEG_W;

  logic [NUM_FEAT-1:0][NUM_CAT-1:0][DEG_W-1:0] featReg;
  logic [NUM_CAT-1:0][DEG_W-1:0]               cur;
  logic [NUM_CAT-1:0]                          sig;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) featReg <= '0;
    else if (ctrl.capture) featReg <= degBus;
  end

  assign cur = featReg[ctrl.featSel];

  for (genvar c = 0; c < NUM_CAT; c++) begin : g_sig
    assign sig[c] = cur[c] > DEG_W'(THRESH);
  end

  always_comb begin
    win = WIN_NONE;
    if (sig[CAT_HIGH] && cur[CAT_HIGH] >= cur[CAT_MED] && cur[CAT_HIGH] >= cur[CAT_LOW])
      win = WIN_HIGH;
    else if (sig[CAT_MED] && cur[CAT_MED] >= cur[CAT_LOW])
      win = WIN_MED;
    else if (sig[CAT_LOW])
      win = WIN_LOW;
  end

  // R2: snapshot equals the bus seen at the capture edge
  a_r2_capture: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.capture |=> featReg == BUS_W'($past(degBus)));
  // R2: snapshot untouched between captures
  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.capture |=> $stable(featReg));
  // R4: a chosen category always clears the threshold
  a_r4_win_sig: assert property (@(posedge clk) disable iff (!rstN)
    (win == WIN_HIGH |-> cur[CAT_HIGH] > DEG_W'(THRESH)) and
    (win == WIN_LOW  |-> cur[CAT_LOW]  > DEG_W'(THRESH)));
  // R5: a High winner is never smaller than the other two
  a_r5_high_max: assert property (@(posedge clk) disable iff (!rstN)
    win == WIN_HIGH |-> (cur[CAT_HIGH] >= cur[CAT_MED] && cur[CAT_HIGH] >= cur[CAT_LOW]));
endmodule

// File: rtl/fzc_control.sv
module fzc_control
  import fzc_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  startIn,
  input  win_e  win,
  output ctrl_s ctrl,
  output logic  doneOut,
  output logic  attackOut
);
  state_e state, nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (startIn) nxt = ST_HAM;
      ST_HAM, ST_ENG, ST_PEAK, ST_MEAN: begin
        if (win == WIN_HIGH)     nxt = ST_ATK;
        else if (win == WIN_LOW) nxt = ST_NORM;
        else begin
          unique case (state)
            ST_HAM:  nxt = ST_ENG;
            ST_ENG:  nxt = ST_PEAK;
            ST_PEAK: nxt = ST_MEAN;
            default: nxt = ST_NORM;
          endcase
        end
      end
      ST_ATK, ST_NORM: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    ctrl.capture = (state == ST_IDLE) && startIn;
    unique case (state)
      ST_ENG:  ctrl.featSel = SEL_W'(1);
      ST_PEAK: ctrl.featSel = SEL_W'(2);
      ST_MEAN: ctrl.featSel = SEL_W'(3);
      default: ctrl.featSel = SEL_W'(0);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      doneOut   <= 1'b0;
      attackOut <= 1'b0;
    end else begin
      state   <= nxt;
      doneOut <= (nxt == ST_ATK) || (nxt == ST_NORM);
      if (nxt == ST_ATK)  attackOut <= 1'b1;
      if (nxt == ST_NORM) attackOut <= 1'b0;
    end
  end

  // R9: done lasts a single cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);
  // R7: verdict changes only alongside done
  a_r7_attack_with_done: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(attackOut) |-> doneOut);
  // R10: a busy machine never restarts at the first stage
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    state != ST_IDLE |=> state != ST_HAM);
  // R8: the mean stage always ends the run
  a_r8_mean_ends: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_MEAN |=> (state == ST_ATK || state == ST_NORM));
  // R9: after a verdict the machine is idle
  a_r9_back_idle: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ATK || state == ST_NORM) |=> state == ST_IDLE);
endmodule

// File: rtl/fuzzy_stage_classifier.sv
module fuzzy_stage_classifier
  import fzc_pkg::*;
#(
  parameter int DEG_W  = 11,
  parameter int THRESH = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       startIn,
  input  logic [NUM_CAT*DEG_W-1:0]   hamDeg,
  input  logic [NUM_CAT*DEG_W-1:0]   energyDeg,
  input  logic [NUM_CAT*DEG_W-1:0]   peakDeg,
  input  logic [NUM_CAT*DEG_W-1:0]   meanDeg,
  output logic                       doneOut,
  output logic                       attackOut
);
  ctrl_s ctrl;
  win_e  win;
  logic [NUM_FEAT*NUM_CAT*DEG_W-1:0] degBus;

  assign degBus = {meanDeg, peakDeg, energyDeg, hamDeg};

  fzc_datapath #(.DEG_W(DEG_W), .THRESH(THRESH)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .degBus(degBus), .win(win)
  );

  fzc_control u_ctl (
    .clk(clk), .rstN(rstN), .startIn(startIn), .win(win),
    .ctrl(ctrl), .doneOut(doneOut), .attackOut(attackOut)
  );
endmodule

// File: tb/fuzzy_stage_classifier_tb.sv
`timescale 1ns/1ps
module fuzzy_stage_classifier_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startIn = 1'b0;
  logic [32:0] hamDeg = '0, energyDeg = '0, peakDeg = '0, meanDeg = '0;
  logic doneOut, attackOut;
  int nRun = 0, nFail = 0, cyc = 0;

  always #2 clk = ~clk;

  fuzzy_stage_classifier u_dut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .hamDeg(hamDeg),
    .energyDeg(energyDeg), .peakDeg(peakDeg), .meanDeg(meanDeg),
    .doneOut(doneOut), .attackOut(attackOut)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nFail++;
      $display("FAIL watchdog: actual cycles %0d expected < 150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  // R11 packing: {High, Medium, Low}
  function automatic logic [32:0] mk(int l, int m, int h);
    return {11'(h), 11'(m), 11'(l)};
  endfunction

  // 0 none, 1 low, 2 med, 3 high per R4/R5/R6
  function automatic int winOf(logic [32:0] t);
    int l = int'(t[10:0]), m = int'(t[21:11]), h = int'(t[32:22]);
    int best = 0, cat = 0;
    if (l > 8 && l >= best) begin best = l; cat = 1; end
    if (m > 8 && m >= best) begin best = m; cat = 2; end
    if (h > 8 && h >= best) begin best = h; cat = 3; end
    return cat;
  endfunction

  // returns attack*16 + latency (R3, R7, R8)
  function automatic int model(logic [131:0] bus);
    for (int s = 0; s < 4; s++) begin
      int w = winOf(bus[s*33 +: 33]);
      if (w == 3) return 16 + s + 2;
      if (w == 1) return s + 2;
    end
    return 5;
  endfunction

  function automatic logic [32:0] rndTri();
    logic [32:0] t;
    for (int c = 0; c < 3; c++) begin
      int r = int'($urandom % 5);
      int v;
      case (r)
        0: v = int'($urandom % 9);
        1: v = 9 + int'($urandom % 12);
        2: v = int'($urandom % 2048);
        3: v = 8 + int'($urandom % 2);
        default: v = (c == 0) ? 30 : int'(t[(c-1)*11 +: 11]);
      endcase
      t[c*11 +: 11] = 11'(v);
    end
    return t;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(logic [131:0] bus);
    {meanDeg, peakDeg, energyDeg, hamDeg} = bus;
  endtask

  task automatic runCase(logic [131:0] bus, bit busyStart, logic [131:0] alt, string req);
    int exp = model(bus);
    int n = 0;
    bit seen = 0;
    @(negedge clk);
    drive(bus);
    startIn = 1'b1;
    @(negedge clk);
    n = 1;
    drive(alt);  // R2: later changes must not matter
    startIn = busyStart;  // R10: start while busy
    if (doneOut) seen = 1;
    while (!seen && n < 12) begin
      @(negedge clk);
      startIn = 1'b0;
      n++;
      if (doneOut) seen = 1;
    end
    startIn = 1'b0;
    check(seen && n == (exp % 16), {req, " latency"}, n, exp % 16);
    check(attackOut == (exp >= 16), {req, " verdict"}, int'(attackOut), int'(exp >= 16));
    @(negedge clk);
    check(!doneOut, {req, " R9 done single"}, int'(doneOut), 0);
  endtask

  logic [131:0] z = '0;
  logic [131:0] fastHi;

  initial begin
    void'($urandom(32'd2024));
    fastHi = {mk(0,0,0), mk(0,0,0), mk(0,0,0), mk(0,0,500)};
    repeat (3) @(negedge clk);
    check(!attackOut && !doneOut, "R1 reset", int'({attackOut, doneOut}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!attackOut && !doneOut, "R1 idle", int'({attackOut, doneOut}), 0);

    runCase(z, 0, fastHi, "R8 all below threshold");
    runCase({z[131:33], mk(0,0,20)}, 0, z, "R7 high at Hamming");
    // R9: attack held while idle
    repeat (3) @(negedge clk);
    check(attackOut && !doneOut, "R9 hold", int'(attackOut), 1);
    runCase({z[131:33], mk(20,0,0)}, 0, fastHi, "R7 low at Hamming");
    runCase({z[131:66], mk(0,0,30), mk(0,20,0)}, 0, z, "R3 med then energy high");
    runCase({mk(0,0,0), mk(0,0,9), mk(0,0,0), mk(8,8,8)}, 0, z, "R4 threshold equal 8");
    runCase({z[131:33], mk(50,50,50)}, 0, z, "R6 three-way tie");
    runCase({z[131:66], mk(12,0,0), mk(50,50,0)}, 0, z, "R6 med over low tie");
    runCase({z[131:33], mk(0,40,40)}, 0, z, "R6 high over med tie");
    runCase({z[131:33], mk(100,0,30)}, 0, fastHi, "R5 largest wins");
    runCase({mk(0,0,100), z[98:0]}, 0, z, "R3 mean high");
    runCase({mk(0,100,0), z[98:0]}, 0, z, "R8 mean med");
    runCase(z, 1, fastHi, "R10 start while busy");
    runCase({mk(9,10,11), mk(0,0,0), mk(0,0,0), mk(0,0,0)}, 1, fastHi, "R10 busy late");

    for (int i = 0; i < 300; i++) begin
      logic [131:0] b = {rndTri(), rndTri(), rndTri(), rndTri()};
      logic [131:0] a = {rndTri(), rndTri(), rndTri(), rndTri()};
      runCase(b, bit'($urandom % 2), a, "R2 R3 R5 random");
    end

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule